// File: doc/BRIEF.md
# Rotating Framebuffer Address Walker

This block produces the byte addresses needed to fetch one colour plane of a source rectangle from a framebuffer. The rectangle can be read at 0, 90, 180 or 270 degrees of rotation. On a start strobe it captures the rectangle, the line pitch, the pixel size, the rotation and the plane's subsampling. It then works out three values: a start offset, a signed step taken between pixels and a signed step taken at the end of each line. Finally it streams one address per clock, pixel by pixel and line by line.

Each rotation begins at a different corner of the rectangle and uses its own pair of strides. Because of this, one fixed rule reads the buffer in rotated order: add the pixel size plus the pixel stride after each pixel, or the pixel size plus the line stride after the last pixel of a line. Chroma planes (index 1 and above) use coordinates divided by their subsampling factors. A fixed per-plane base offset is added to the start offset.

The controller is a four-state machine:
- `ST_IDLE` waits for an accepted start. Its transition is *accept* when start is high and both dimensions are nonzero.
- `ST_CALC` registers the computed values. Its transition is *latch*, which always goes on to `ST_WALK`.
- `ST_WALK` emits one address per cycle. Its transition is *finish*, taken on the final address, into `ST_DONE`.
- `ST_DONE` pulses done for one cycle. Its transition is *rearm*, back to `ST_IDLE`.

Top module: `fb_rot_walker`

## Requirements
- R1: After reset, addr_valid, addr_last and done are 0, and start_offset, line_stride and pix_stride are 0.
- R2: A start accepted in `ST_IDLE` at clock edge E makes addr_valid high from edge E+2. It then gives exactly W' addresses per line for H' lines on consecutive cycles, with no gap. addr_last is high on the final address only, and done is high for exactly the one cycle after it. For rotation codes 1 and 3, W' = src_h and H' = src_w; otherwise W' = src_w and H' = src_h.
- R3: When the current address is not the last of its line, the next address is that address plus bpp plus pix_stride. When it is the last of its line, the next address is that address plus bpp plus line_stride. All arithmetic is modulo 2^32.
- R4: For rotation code 0, start_offset = base + (y>>sy)·pitch + (x>>sx)·bpp, pix_stride = 0 and line_stride = pitch − (W'>>sx)·bpp. For plane 0 this reads rows y.. downward and columns x.. rightward.
- R5: For rotation code 2 (180 degrees), the start row is (y+H'−1)>>sy and the start column is (x+W'−1)>>sx. pix_stride = −2·bpp and line_stride = (((W'−1)>>sx) − 1)·bpp − pitch.
- R6: For rotation code 1 (90 degrees), the start row is (y+W'−1)>>sy and the start column is x>>sx. line_stride = ((W'−1)>>sy)·pitch and pix_stride = −pitch − bpp.
- R7: For rotation code 3 (270 degrees), the start row is y>>sy and the start column is (x+H'−1)>>sx. line_stride = −((W'−1)>>sy)·pitch − 2·bpp and pix_stride = pitch − bpp.
- R8: sx = hsub_log2 and sy = vsub_log2 when plane_idx ≠ 0. When plane_idx = 0, sx = sy = 0 whatever the subsampling inputs are.
- R9: plane_base is added to start_offset, and the sum wraps modulo 2^32.
- R10: A start strobe during `ST_CALC`, `ST_WALK` or `ST_DONE` is ignored. Input changes during a walk do not alter the stream or the three reported values.
- R11: A start with src_w = 0 or src_h = 0 is ignored: no address and no done follow.
- R12: The first address of a walk equals start_offset, and start_offset, line_stride and pix_stride stay constant from then until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, sampled in `ST_IDLE` |
| src_x | input | CW | Rectangle left column in pixels |
| src_y | input | CW | Rectangle top row in pixels |
| src_w | input | CW | Rectangle width in pixels |
| src_h | input | CW | Rectangle height in pixels |
| pitch | input | PW | Bytes per framebuffer line |
| bpp | input | BW | Bytes per pixel |
| rot | input | 2 | 0: 0°, 1: 90°, 2: 180°, 3: 270° |
| plane_idx | input | PLW | Colour plane index, 0 is luma or packed |
| hsub_log2 | input | 2 | log2 of the horizontal subsampling divisor |
| vsub_log2 | input | 2 | log2 of the vertical subsampling divisor |
| plane_base | input | AW | Fixed byte offset of the plane |
| start_offset | output | AW | Computed first address |
| line_stride | output | AW | Signed step used after the last pixel of a line |
| pix_stride | output | AW | Signed step used after other pixels |
| addr | output | AW | Current fetch address |
| addr_valid | output | 1 | addr is meaningful this cycle |
| addr_last | output | 1 | Final address of the walk |
| done | output | 1 | One-cycle pulse after the final address |

## Verification
For plane 0, each rotation code is run on a non-square rectangle, and every streamed address is compared against one computed directly from the geometric position of each pixel. This separates a wrong start corner or a wrong stride sign from a missed width/height swap. Chroma runs with nonzero subsampling compare the reported offset and strides with the formulas and follow the stepping rule. A plane-0 run with nonzero subsampling inputs shows that they are ignored. A base near 2^32 exercises wrap-around, and a 1×1 rectangle exercises the single-address boundary. A start held high from mid-walk through `ST_DONE` must leave the stream intact and launch nothing, and a zero-width start must launch nothing.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

    typedef enum logic [1:0] {
        ROT_0   = 2'd0,
        ROT_90  = 2'd1,
        ROT_180 = 2'd2,
        ROT_270 = 2'd3
    } fbw_rot_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_WALK = 2'd2,
        ST_DONE = 2'd3
    } fbw_state_e;

endpackage

// File: rtl/fbw_geom.sv
module fbw_geom
    import fbw_pkg::*;
#(
    parameter int CW  = 12,
    parameter int PW  = 16,
    parameter int BW  = 3,
    parameter int AW  = 32,
    parameter int PLW = 2
) (
    input  logic [CW-1:0]  x,
    input  logic [CW-1:0]  y,
    input  logic [CW-1:0]  w,
    input  logic [CW-1:0]  h,
    input  logic [PW-1:0]  pitch,
    input  logic [BW-1:0]  bpp,
    input  logic [1:0]     rot,
    input  logic [PLW-1:0] plane_idx,
    input  logic [1:0]     hsub,
    input  logic [1:0]     vsub,
    input  logic [AW-1:0]  base,
    output logic [AW-1:0]  off,
    output logic [AW-1:0]  xs,
    output logic [AW-1:0]  ps,
    output logic [CW-1:0]  run_w,
    output logic [CW-1:0]  run_h
);

    localparam int CPAD = AW - CW;
    localparam int PPAD = AW - PW;
    localparam int BPAD = AW - BW;

    fbw_rot_e       r;
    logic [1:0]     shf [2];
    logic [AW-1:0]  cx, cy, cwid, chgt, cp, cb, wm1;
    logic [AW-1:0]  row, col;

    assign r = fbw_rot_e'(rot);

    // axis 0 is horizontal, axis 1 vertical; plane 0 never subsamples
    generate
        for (genvar a = 0; a < 2; a++) begin : g_axis
            if (a == 0) begin : g_h
                assign shf[a] = (plane_idx == '0) ? 2'd0 : hsub;
            end else begin : g_v
                assign shf[a] = (plane_idx == '0) ? 2'd0 : vsub;
            end
        end
    endgenerate

    // quarter turns exchange the walk dimensions
    assign run_w = rot[0] ? h : w;
    assign run_h = rot[0] ? w : h;

    assign cx   = {{CPAD{1'b0}}, x};
    assign cy   = {{CPAD{1'b0}}, y};
    assign cwid = {{CPAD{1'b0}}, run_w};
    assign chgt = {{CPAD{1'b0}}, run_h};
    assign cp   = {{PPAD{1'b0}}, pitch};
    assign cb   = {{BPAD{1'b0}}, bpp};
    assign wm1  = cwid - 1'b1;

    always_comb begin
        unique case (r)
            ROT_0: begin
                row = cy >> shf[1];
                col = cx >> shf[0];
                xs  = cp - ((cwid >> shf[0]) * cb);
                ps  = '0;
            end
            ROT_180: begin
                row = (cy + chgt - 1'b1) >> shf[1];
                col = (cx + cwid - 1'b1) >> shf[0];
                xs  = (((wm1 >> shf[0]) - 1'b1) * cb) - cp;
                ps  = '0 - (cb << 1);
            end
            ROT_90: begin
                row = (cy + cwid - 1'b1) >> shf[1];
                col = cx >> shf[0];
                xs  = (wm1 >> shf[1]) * cp;
                ps  = '0 - cp - cb;
            end
            ROT_270: begin
                row = cy >> shf[1];
                col = (cx + chgt - 1'b1) >> shf[0];
                xs  = '0 - ((wm1 >> shf[1]) * cp) - (cb << 1);
                ps  = cp - cb;
            end
        endcase
    end

    assign off = base + (row * cp) + (col * cb);

endmodule

// File: rtl/fbw_walk.sv
module fbw_walk
    import fbw_pkg::*;
#(
    parameter int CW = 12,
    parameter int BW = 3,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dims_ok,
    input  logic [AW-1:0] g_off,
    input  logic [AW-1:0] g_xs,
    input  logic [AW-1:0] g_ps,
    input  logic [CW-1:0] g_w,
    input  logic [CW-1:0] g_h,
    input  logic [BW-1:0] bpp,
    output logic          load_cfg,
    output logic [AW-1:0] start_offset,
    output logic [AW-1:0] line_stride,
    output logic [AW-1:0] pix_stride,
    output logic [AW-1:0] addr,
    output logic          addr_valid,
    output logic          addr_last,
    output logic          done
);

    localparam int BPAD = AW - BW;

    fbw_state_e     state, nxt;
    logic [CW-1:0]  px, ln, wlen, hlen;
    logic           eol, at_end, latch;
    logic [AW-1:0]  step;

    assign eol    = (px == (wlen - 1'b1));
    assign at_end = eol && (ln == (hlen - 1'b1));
    assign step   = {{BPAD{1'b0}}, bpp} + (eol ? line_stride : pix_stride);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions: accept, latch, finish, rearm
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start && dims_ok) nxt = ST_CALC;
            ST_CALC: nxt = ST_WALK;
            ST_WALK: if (at_end) nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        load_cfg   = 1'b0;
        latch      = 1'b0;
        addr_valid = 1'b0;
        addr_last  = 1'b0;
        done       = 1'b0;
        unique case (state)
            ST_IDLE: load_cfg = start && dims_ok;
            ST_CALC: latch = 1'b1;
            ST_WALK: begin
                addr_valid = 1'b1;
                addr_last  = at_end;
            end
            ST_DONE: done = 1'b1;
        endcase
    end

    // address accumulator and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_offset <= '0;
            line_stride  <= '0;
            pix_stride   <= '0;
            addr         <= '0;
            px           <= '0;
            ln           <= '0;
            wlen         <= '0;
            hlen         <= '0;
        end else if (latch) begin
            start_offset <= g_off;
            line_stride  <= g_xs;
            pix_stride   <= g_ps;
            addr         <= g_off;
            px           <= '0;
            ln           <= '0;
            wlen         <= g_w;
            hlen         <= g_h;
        end else if (addr_valid) begin
            addr <= addr + step;
            if (eol) begin
                px <= '0;
                ln <= ln + 1'b1;
            end else begin
                px <= px + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fb_rot_walker.sv
module fb_rot_walker
    import fbw_pkg::*;
#(
    parameter int CW  = 12,
    parameter int PW  = 16,
    parameter int BW  = 3,
    parameter int AW  = 32,
    parameter int NPL = 3,
    parameter int PLW = (NPL > 1) ? $clog2(NPL) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [CW-1:0]  src_x,
    input  logic [CW-1:0]  src_y,
    input  logic [CW-1:0]  src_w,
    input  logic [CW-1:0]  src_h,
    input  logic [PW-1:0]  pitch,
    input  logic [BW-1:0]  bpp,
    input  logic [1:0]     rot,
    input  logic [PLW-1:0] plane_idx,
    input  logic [1:0]     hsub_log2,
    input  logic [1:0]     vsub_log2,
    input  logic [AW-1:0]  plane_base,
    output logic [AW-1:0]  start_offset,
    output logic [AW-1:0]  line_stride,
    output logic [AW-1:0]  pix_stride,
    output logic [AW-1:0]  addr,
    output logic           addr_valid,
    output logic           addr_last,
    output logic           done
);

    logic           load_cfg, dims_ok;
    logic [CW-1:0]  k_x, k_y, k_w, k_h;
    logic [PW-1:0]  k_pitch;
    logic [BW-1:0]  k_bpp;
    logic [1:0]     k_rot, k_hs, k_vs;
    logic [PLW-1:0] k_pl;
    logic [AW-1:0]  k_base;
    logic [AW-1:0]  g_off, g_xs, g_ps;
    logic [CW-1:0]  g_w, g_h;

    assign dims_ok = (src_w != '0) && (src_h != '0);

    // request capture, only on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_x     <= '0;
            k_y     <= '0;
            k_w     <= '0;
            k_h     <= '0;
            k_pitch <= '0;
            k_bpp   <= '0;
            k_rot   <= '0;
            k_hs    <= '0;
            k_vs    <= '0;
            k_pl    <= '0;
            k_base  <= '0;
        end else if (load_cfg) begin
            k_x     <= src_x;
            k_y     <= src_y;
            k_w     <= src_w;
            k_h     <= src_h;
            k_pitch <= pitch;
            k_bpp   <= bpp;
            k_rot   <= rot;
            k_hs    <= hsub_log2;
            k_vs    <= vsub_log2;
            k_pl    <= plane_idx;
            k_base  <= plane_base;
        end
    end

    fbw_geom #(
        .CW(CW), .PW(PW), .BW(BW), .AW(AW), .PLW(PLW)
    ) i_geom (
        .x(k_x), .y(k_y), .w(k_w), .h(k_h),
        .pitch(k_pitch), .bpp(k_bpp), .rot(k_rot),
        .plane_idx(k_pl), .hsub(k_hs), .vsub(k_vs), .base(k_base),
        .off(g_off), .xs(g_xs), .ps(g_ps), .run_w(g_w), .run_h(g_h)
    );

    fbw_walk #(
        .CW(CW), .BW(BW), .AW(AW)
    ) i_walk (
        .clk(clk), .rst_n(rst_n), .start(start), .dims_ok(dims_ok),
        .g_off(g_off), .g_xs(g_xs), .g_ps(g_ps), .g_w(g_w), .g_h(g_h),
        .bpp(k_bpp), .load_cfg(load_cfg),
        .start_offset(start_offset), .line_stride(line_stride),
        .pix_stride(pix_stride), .addr(addr), .addr_valid(addr_valid),
        .addr_last(addr_last), .done(done)
    );

endmodule

// File: rtl/fbw_chk.sv
module fbw_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] start_offset,
    input logic [AW-1:0] line_stride,
    input logic [AW-1:0] pix_stride,
    input logic [AW-1:0] addr,
    input logic          addr_valid,
    input logic          addr_last,
    input logic          done
);

    // R2
    last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_last |-> addr_valid);

    // R2
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_last) |=> (done && !addr_valid));

    // R2
    stream_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_last) |=> addr_valid);

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !addr_valid));

    // R12
    first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_valid) |-> (addr == start_offset));

    // R10
    cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> ($stable(start_offset) && $stable(line_stride) && $stable(pix_stride)));

endmodule

bind fb_rot_walker fbw_chk #(.AW(AW)) i_fbw_chk (
    .clk(clk), .rst_n(rst_n), .start_offset(start_offset),
    .line_stride(line_stride), .pix_stride(pix_stride), .addr(addr),
    .addr_valid(addr_valid), .addr_last(addr_last), .done(done)
);

// File: tb/test_fb_rot_walker.sv
module test_fb_rot_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] src_x = '0, src_y = '0, src_w = '0, src_h = '0;
    logic [15:0] pitch = '0;
    logic [2:0]  bpp = '0;
    logic [1:0]  rot = '0;
    logic [1:0]  plane_idx = '0;
    logic [1:0]  hsub_log2 = '0, vsub_log2 = '0;
    logic [31:0] plane_base = '0;
    logic [31:0] start_offset, line_stride, pix_stride, addr;
    logic        addr_valid, addr_last, done;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    logic [31:0] e_off, e_xs, e_ps;

    always #10 clk = ~clk;

    fb_rot_walker i_fb_rot_walker (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_x(src_x), .src_y(src_y), .src_w(src_w), .src_h(src_h),
        .pitch(pitch), .bpp(bpp), .rot(rot), .plane_idx(plane_idx),
        .hsub_log2(hsub_log2), .vsub_log2(vsub_log2), .plane_base(plane_base),
        .start_offset(start_offset), .line_stride(line_stride),
        .pix_stride(pix_stride), .addr(addr), .addr_valid(addr_valid),
        .addr_last(addr_last), .done(done)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic set_in(input int x, input int y, input int w, input int h,
                          input int p, input int b, input int r, input int pl,
                          input int hs, input int vs, input logic [31:0] base);
        src_x = 12'(x); src_y = 12'(y); src_w = 12'(w); src_h = 12'(h);
        pitch = 16'(p); bpp = 3'(b); rot = 2'(r); plane_idx = 2'(pl);
        hsub_log2 = 2'(hs); vsub_log2 = 2'(vs); plane_base = base;
    endtask

    // expected reported values, straight from the formulas in R4..R9
    task automatic calc_exp();
        logic [31:0] X, Y, W, H, P, B, row, col, wm1;
        int sx, sy;
        sx = (plane_idx != 0) ? int'(hsub_log2) : 0;
        sy = (plane_idx != 0) ? int'(vsub_log2) : 0;
        X = 32'(src_x); Y = 32'(src_y); P = 32'(pitch); B = 32'(bpp);
        W = rot[0] ? 32'(src_h) : 32'(src_w);
        H = rot[0] ? 32'(src_w) : 32'(src_h);
        wm1 = W - 1;
        case (rot)
            2'd0: begin row = Y >> sy; col = X >> sx;
                  e_xs = P - ((W >> sx) * B); e_ps = 0; end
            2'd2: begin row = (Y + H - 1) >> sy; col = (X + W - 1) >> sx;
                  e_xs = (((wm1 >> sx) - 1) * B) - P; e_ps = 0 - 2 * B; end
            2'd1: begin row = (Y + W - 1) >> sy; col = X >> sx;
                  e_xs = (wm1 >> sy) * P; e_ps = 0 - P - B; end
            default: begin row = Y >> sy; col = (X + H - 1) >> sx;
                  e_xs = 0 - ((wm1 >> sy) * P) - 2 * B; e_ps = P - B; end
        endcase
        e_off = plane_base + row * P + col * B;
    endtask

    // expected stream: geometric for plane 0, stepping rule (R3) otherwise
    task automatic build_q();
        int we, he, row, col;
        logic [31:0] a;
        exp_q.delete();
        we = rot[0] ? int'(src_h) : int'(src_w);
        he = rot[0] ? int'(src_w) : int'(src_h);
        a = e_off;
        for (int l = 0; l < he; l++) begin
            for (int p = 0; p < we; p++) begin
                if (plane_idx == 0) begin
                    case (rot)
                        2'd0: begin row = int'(src_y) + l; col = int'(src_x) + p; end
                        2'd1: begin row = int'(src_y) + we - 1 - p; col = int'(src_x) + l; end
                        2'd2: begin row = int'(src_y) + he - 1 - l; col = int'(src_x) + we - 1 - p; end
                        default: begin row = int'(src_y) + p; col = int'(src_x) + he - 1 - l; end
                    endcase
                    exp_q.push_back(plane_base + 32'(row) * 32'(pitch) + 32'(col) * 32'(bpp));
                end else begin
                    exp_q.push_back(a);
                    a = a + 32'(bpp) + ((p == we - 1) ? e_xs : e_ps);
                end
            end
        end
    endtask

    task automatic run_walk(input string tag, input bit interfere);
        int n;
        calc_exp();
        build_q();
        n = exp_q.size();
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        chk(tag, "R2 no valid one cycle after start", 32'(addr_valid), 0);
        @(posedge clk);
        @(negedge clk);
        chk(tag, "R12 start_offset", start_offset, e_off);
        chk(tag, "line_stride", line_stride, e_xs);
        chk(tag, "pix_stride", pix_stride, e_ps);
        for (int i = 0; i < n; i++) begin
            chk(tag, "R2 valid", 32'(addr_valid), 1);
            chk(tag, "R3 addr", addr, exp_q[i]);
            chk(tag, "R2 last", 32'(addr_last), (i == n - 1) ? 1 : 0);
            if (interfere && i == 1) begin
                start = 1'b1;            // R10: must be ignored
                src_x = src_x + 12'd5;
                rot = rot + 2'd1;
            end
            @(posedge clk);
            @(negedge clk);
        end
        chk(tag, "R2 done", 32'(done), 1);
        chk(tag, "R2 valid after last", 32'(addr_valid), 0);
        if (interfere) begin
            @(posedge clk);
            @(negedge clk); start = 1'b0;
            for (int k = 0; k < 3; k++) begin
                chk(tag, "R10 no relaunch", 32'(addr_valid | done), 0);
                @(posedge clk);
                @(negedge clk);
            end
        end else begin
            @(posedge clk);
            @(negedge clk);
            chk(tag, "R2 done single", 32'(done), 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid", 32'(addr_valid), 0);
        chk("R1", "done", 32'(done), 0);
        chk("R1", "last", 32'(addr_last), 0);
        chk("R1", "offset", start_offset, 0);
        chk("R1", "strides", line_stride | pix_stride, 0);

        set_in(3, 2, 4, 3, 64, 2, 0, 0, 0, 0, 32'h1000); run_walk("R4", 0);
        set_in(3, 2, 4, 3, 64, 2, 2, 0, 0, 0, 32'h1000); run_walk("R5", 0);
        set_in(3, 2, 4, 3, 64, 2, 1, 0, 0, 0, 32'h1000); run_walk("R6", 0);
        set_in(3, 2, 4, 3, 64, 2, 3, 0, 0, 0, 32'h1000); run_walk("R7", 0);
        set_in(5, 7, 4, 3, 64, 4, 1, 0, 1, 1, 32'h0);    run_walk("R8 plane0", 0);
        set_in(5, 7, 6, 4, 32, 1, 0, 1, 1, 1, 32'h200);  run_walk("R8 r0", 0);
        set_in(5, 7, 6, 4, 32, 2, 2, 2, 1, 0, 32'h200);  run_walk("R8 r180", 0);
        set_in(5, 7, 6, 4, 32, 1, 1, 1, 1, 1, 32'h200);  run_walk("R8 r90", 0);
        set_in(5, 7, 6, 4, 32, 2, 3, 1, 2, 1, 32'h200);  run_walk("R8 r270", 0);
        set_in(1, 1, 3, 2, 16, 4, 0, 0, 0, 0, 32'hFFFF_FFF0); run_walk("R9", 0);
        set_in(0, 0, 1, 1, 8, 1, 2, 0, 0, 0, 32'h40);    run_walk("R2 1x1", 0);
        set_in(2, 3, 3, 2, 40, 2, 0, 0, 0, 0, 32'h80);   run_walk("R10", 1);

        set_in(2, 3, 0, 2, 40, 2, 0, 0, 0, 0, 32'h80);
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R11", "zero width no walk", 32'(addr_valid | done), 0);
            @(posedge clk);
            @(negedge clk);
        end
        set_in(2, 3, 2, 2, 40, 2, 3, 0, 0, 0, 32'h80); run_walk("R11 after", 0);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule